// File: doc/BRIEF.md
# Block Transfer Bus Master

This block moves a run of data beats between a user-side command port and a shared bus that follows Wishbone classic conventions. A single command gives a start address, a beat count, a direction, a byte-lane select and a mode. The master then holds the bus cycle signal high for the whole run and issues one request per beat. It captures read beats as they are acknowledged and takes write beats from the user as each request goes out.

The block has two modes. Standard mode runs each beat as a full handshake and puts a one-clock master wait state between beats. Pipelined mode puts a new request on the bus on the clock after the previous one is accepted, and it holds a request unchanged while the slave stalls. In pipelined mode, an outstanding-request counter keeps the cycle signal high until every acknowledge has come back.

Top module: `wb_block_master`

## Requirements
- R1: `cmd_ready` is high only while no block is running. A command with `cmd_valid` high and a nonzero `cmd_len` is taken at a clock edge where `cmd_ready` is high. On the next clock `wb_cyc` and `wb_stb` are high, with `wb_adr`=`cmd_addr`, `wb_sel`=`cmd_sel` and `wb_we`=`cmd_write`. A command with `cmd_len` of 0 is ignored: `wb_cyc` stays low and `cmd_ready` stays high.
- R2: `wb_cyc` rises once per block and stays high without a break until the clock after the final acknowledge. At that clock it falls and `cmd_ready` returns high. `wb_stb` is never high while `wb_cyc` is low.
- R3: In a read block, each acknowledged beat's `wb_dat_i` appears on `rd_data` with `rd_valid` high for exactly one clock, on the clock after the acknowledge. Beats come out in address order, one per beat.
- R4: Standard mode (`cmd_pipe`=0): after each acknowledge that is not the last, `wb_stb` drops for exactly one clock while `wb_cyc` stays high. After the last acknowledge, `wb_stb` and `wb_cyc` drop together. With a slave that acknowledges one clock after it sees the strobe, a block of N beats keeps `wb_cyc` high for 4N-1 clocks.
- R5: Pipelined mode: a clock in which `wb_stb` and `wb_stall` are both high is followed by a clock with `wb_stb` high and `wb_adr`, `wb_sel` and `wb_dat_o` unchanged.
- R6: Pipelined mode (`cmd_pipe`=1): a request is accepted when `wb_stb` is high and `wb_stall` is low. The next request appears on the following clock without waiting for an acknowledge. `wb_stb` drops after the last acceptance, and `wb_cyc` stays high until every outstanding request has been acknowledged. With no stall and a slave that acknowledges one clock after acceptance, N beats keep `wb_cyc` high for N+2 clocks.
- R7: In a write block, beat k of the user stream is presented on `wb_dat_o` in the request for address base+4k. `wr_take` pulses exactly once per beat, in the clock in which the master consumes `wr_data`.
- R8: Each block issues exactly `cmd_len` requests. Their addresses step by the port width in bytes (4 at the default width) from `cmd_addr`, and `wb_we` and `wb_sel` stay constant across the block.
- R9: In standard mode `wb_stall` has no effect: the requests, the data and the beat timing of R4 are the same whatever the stall input does.
- R10: After reset `wb_cyc`, `wb_stb` and `rd_valid` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start command request |
| cmd_ready | output | 1 | High while idle, when a command can be taken |
| cmd_addr | input | AW | Byte address of the first beat |
| cmd_len | input | LW | Number of beats; 0 is ignored |
| cmd_write | input | 1 | 1 selects write, 0 selects read |
| cmd_sel | input | DW/8 | Byte-lane select used for every beat |
| cmd_pipe | input | 1 | 1 selects pipelined mode, 0 standard mode |
| wr_data | input | DW | Next write beat from the user |
| wr_take | output | 1 | `wr_data` is consumed at the coming edge |
| rd_data | output | DW | Captured read beat |
| rd_valid | output | 1 | One-clock pulse qualifying `rd_data` |
| wb_cyc | output | 1 | Bus cycle, held for the whole block |
| wb_stb | output | 1 | Request strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | AW | Request byte address |
| wb_sel | output | DW/8 | Byte-lane select |
| wb_dat_o | output | DW | Write data to the slave |
| wb_ack | input | 1 | Acknowledge from the slave |
| wb_stall | input | 1 | Slave stall, used in pipelined mode only |
| wb_dat_i | input | DW | Read data from the slave |

## Verification
The assertions assume a well-behaved slave. It never acknowledges while no request is outstanding in pipelined mode, or while the strobe is low in standard mode. Its acknowledge is registered, so it never arrives in the clock in which the request is accepted. The bench slave meets this by keeping a queue of accepted requests and acknowledging only from a non-empty queue, one clock or more later. In standard mode it takes a new request only when the queue is empty and no acknowledge is showing. The random acknowledge delays and stall patterns vary timing only inside these limits.

// File: rtl/wb_block_master.sv
module wb_block_master #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [LW-1:0]   cmd_len,
  input  logic            cmd_write,
  input  logic [DW/8-1:0] cmd_sel,
  input  logic            cmd_pipe,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_take,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic            wb_cyc,
  output logic            wb_stb,
  output logic            wb_we,
  output logic [AW-1:0]   wb_adr,
  output logic [DW/8-1:0] wb_sel,
  output logic [DW-1:0]   wb_dat_o,
  input  logic            wb_ack,
  input  logic            wb_stall,
  input  logic [DW-1:0]   wb_dat_i
);
  localparam logic [AW-1:0] STEP = AW'(DW/8);

  typedef enum logic [1:0] {S_IDLE, S_PHASE, S_GAP, S_DRAIN} state_t;
  state_t state;

  logic          pipe_r;
  logic [LW-1:0] iss_left, ack_left, out_cnt, len_r;
  logic          start, accept, ack_in, last_iss, last_ack;

  assign cmd_ready = (state == S_IDLE);
  assign start     = cmd_valid && cmd_ready && (cmd_len != '0);
  assign accept    = (state == S_PHASE) && pipe_r && !wb_stall;
  assign ack_in    = wb_cyc && wb_ack && (pipe_r ? (out_cnt != '0) : wb_stb);
  assign last_iss  = (iss_left == LW'(1));
  assign last_ack  = (ack_left == LW'(1));
  assign wr_take   = (start && cmd_write)
                   || (wb_we && accept && !last_iss)
                   || (wb_we && state == S_GAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wb_cyc   <= 1'b0;
      wb_stb   <= 1'b0;
      wb_we    <= 1'b0;
      wb_adr   <= '0;
      wb_sel   <= '0;
      wb_dat_o <= '0;
      pipe_r   <= 1'b0;
      iss_left <= '0;
      ack_left <= '0;
      out_cnt  <= '0;
      len_r    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= ack_in && !wb_we;
      if (ack_in && !wb_we) rd_data <= wb_dat_i;
      case (state)
        S_IDLE: if (start) begin
          wb_cyc   <= 1'b1;
          wb_stb   <= 1'b1;
          wb_we    <= cmd_write;
          wb_adr   <= cmd_addr;
          wb_sel   <= cmd_sel;
          if (cmd_write) wb_dat_o <= wr_data;
          pipe_r   <= cmd_pipe;
          iss_left <= cmd_len;
          ack_left <= cmd_len;
          len_r    <= cmd_len;
          out_cnt  <= '0;
          state    <= S_PHASE;
        end
        S_PHASE: if (pipe_r) begin
          out_cnt <= out_cnt + LW'(accept) - LW'(ack_in);
          if (ack_in) ack_left <= ack_left - LW'(1);
          if (accept) begin
            iss_left <= iss_left - LW'(1);
            if (last_iss) begin
              wb_stb <= 1'b0;
              state  <= S_DRAIN;
            end else begin
              wb_adr <= wb_adr + STEP;
              if (wb_we) wb_dat_o <= wr_data;
            end
          end
        end else if (ack_in) begin
          ack_left <= ack_left - LW'(1);
          iss_left <= iss_left - LW'(1);
          wb_stb   <= 1'b0;
          if (last_ack) begin
            wb_cyc <= 1'b0;
            state  <= S_IDLE;
          end else begin
            wb_adr <= wb_adr + STEP;
            state  <= S_GAP;
          end
        end
        S_GAP: begin
          wb_stb <= 1'b1;
          if (wb_we) wb_dat_o <= wr_data;
          state  <= S_PHASE;
        end
        S_DRAIN: if (ack_in) begin
          out_cnt  <= out_cnt - LW'(1);
          ack_left <= ack_left - LW'(1);
          if (last_ack) begin
            wb_cyc <= 1'b0;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ZERO_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_len == '0 |=> !wb_cyc); // R1
  AST_STB_INSIDE_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb |-> wb_cyc); // R2
  AST_CYC_ENDS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wb_cyc) |-> $past(wb_ack)); // R2
  AST_READ_PULSE_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(wb_ack && wb_cyc && !wb_we)); // R3
  AST_SINGLE_WAIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_r && wb_cyc && $fell(wb_stb) |=> wb_stb); // R4
  AST_STALL_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_r && wb_stb && wb_stall |=> wb_stb && $stable(wb_adr) && $stable(wb_sel) && $stable(wb_dat_o)); // R5
  AST_OUTSTANDING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= len_r); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_r && wb_stb && !wb_stall && iss_left > LW'(1) |=> wb_adr == $past(wb_adr) + STEP); // R8
endmodule

// File: tb/wb_block_master_tb.sv
module wb_block_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [7:0]  cmd_len = '0;
  logic        cmd_write = 1'b0;
  logic [3:0]  cmd_sel = '0;
  logic        cmd_pipe = 1'b0;
  logic [31:0] wr_data;
  logic        wr_take;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        wb_cyc, wb_stb, wb_we;
  logic [31:0] wb_adr;
  logic [3:0]  wb_sel;
  logic [31:0] wb_dat_o;
  logic        wb_ack = 1'b0;
  logic        wb_stall = 1'b0;
  logic [31:0] wb_dat_i = '0;

  wb_block_master dut_i (.*);

  always #5 clk = ~clk;

  int pass_n = 0, fail_n = 0, cycles = 0;
  int ack_prob = 100, stall_prob = 0;
  bit pipe_mode = 1'b0;

  logic [31:0] wbeats [0:255];
  int widx = 0, wbase = 0;
  assign wr_data = wbeats[(widx - wbase) & 255];

  logic [31:0] q_adr [0:4095];
  int head = 0, tail = 0;
  logic [31:0] lg_adr [0:4095];
  logic [31:0] lg_dat [0:4095];
  logic [3:0]  lg_sel [0:4095];
  logic        lg_we  [0:4095];
  int nreq = 0;
  int hold_n = 0, hold_seen = 0, stall_bad = 0;
  logic [31:0] h_adr;
  logic [31:0] rd_log [0:4095];
  int nrd = 0;
  int cyc_cnt = 0, cyc_falls = 0;
  bit prev_cyc = 1'b0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  always @(posedge clk) begin
    bit pend;
    bit acc;
    if (rst_n) begin
      pend = (head != tail);
      acc = wb_cyc && wb_stb && (pipe_mode ? !wb_stall : (!wb_ack && !pend));
      if (pipe_mode && wb_cyc && wb_stb && wb_stall) begin
        hold_n = hold_n + 1;
        h_adr = wb_adr;
      end
      if (pend && (($urandom % 100) < ack_prob)) begin
        wb_ack   <= 1'b1;
        wb_dat_i <= memf(q_adr[head & 4095]);
        head = head + 1;
      end else begin
        wb_ack <= 1'b0;
      end
      if (acc) begin
        q_adr[tail & 4095] = wb_adr;
        tail = tail + 1;
        lg_adr[nreq & 4095] = wb_adr;
        lg_dat[nreq & 4095] = wb_dat_o;
        lg_sel[nreq & 4095] = wb_sel;
        lg_we[nreq & 4095]  = wb_we;
        nreq = nreq + 1;
      end
      if (wr_take) widx <= widx + 1;
      if (rd_valid) begin
        rd_log[nrd & 4095] = rd_data;
        nrd = nrd + 1;
      end
    end
  end

  always @(negedge clk) begin
    wb_stall <= (($urandom % 100) < stall_prob);
    if (wb_cyc) cyc_cnt = cyc_cnt + 1;
    if (prev_cyc && !wb_cyc) cyc_falls = cyc_falls + 1;
    prev_cyc = wb_cyc;
    if (hold_n != hold_seen) begin
      if (!(wb_stb && wb_adr == h_adr)) stall_bad = stall_bad + 1;
      hold_seen = hold_n;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      fail_n = fail_n + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 150000", cycles);
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_block(input logic [31:0] base, input int len, input bit wr,
                           input logic [3:0] sel, input bit pipe, input int ap,
                           input int sp, input int exp_cyc);
    int r0, d0, c0, f0, sb0, waited;
    int bad;
    @(negedge clk);
    for (int k = 0; k < 256; k++) wbeats[k] = $urandom;
    wbase = widx;
    r0 = nreq; d0 = nrd; c0 = cyc_cnt; f0 = cyc_falls; sb0 = stall_bad;
    ack_prob = ap; stall_prob = sp; pipe_mode = pipe;
    cmd_addr = base; cmd_len = 8'(len); cmd_write = wr; cmd_sel = sel; cmd_pipe = pipe;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    waited = 0;
    while (!cmd_ready && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    @(negedge clk);
    stall_prob = 0;
    chk(cmd_ready, "R2", "cmd_ready after block", cmd_ready, 1);
    chk(nreq - r0 == len, "R8", "request count", nreq - r0, len);
    bad = 0;
    for (int k = 0; k < len; k++) begin
      if (lg_adr[(r0 + k) & 4095] != base + 32'(4 * k)) bad++;
      if (lg_we[(r0 + k) & 4095] != wr || lg_sel[(r0 + k) & 4095] != sel) bad++;
    end
    chk(bad == 0, "R8", "address/we/sel mismatches", bad, 0);
    if (wr) begin
      bad = 0;
      for (int k = 0; k < len; k++)
        if (lg_dat[(r0 + k) & 4095] != wbeats[k]) bad++;
      chk(bad == 0, "R7", "write data mismatches", bad, 0);
      chk(widx - wbase == len, "R7", "wr_take pulses", widx - wbase, len);
    end else begin
      chk(nrd - d0 == len, "R3", "read beats delivered", nrd - d0, len);
      bad = 0;
      for (int k = 0; k < len; k++)
        if (rd_log[(d0 + k) & 4095] != memf(base + 32'(4 * k))) bad++;
      chk(bad == 0, "R3", "read data mismatches", bad, 0);
      chk(widx == wbase, "R7", "no wr_take in read", widx - wbase, 0);
    end
    chk(cyc_falls - f0 == 1, "R2", "cyc high spans", cyc_falls - f0, 1);
    if (pipe) chk(stall_bad == sb0, "R5", "stalled request changed", stall_bad - sb0, 0);
    if (exp_cyc > 0)
      chk(cyc_cnt - c0 == exp_cyc, pipe ? "R6" : (sp > 0 ? "R9" : "R4"),
          "cyc high clocks", cyc_cnt - c0, exp_cyc);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 256; k++) wbeats[k] = '0;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !wb_cyc && !wb_stb && !rd_valid, "R10", "reset state",
        {cmd_ready, wb_cyc, wb_stb, rd_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);

    cmd_addr = 32'h100; cmd_len = 8'd0; cmd_write = 1'b0; cmd_sel = 4'hF; cmd_pipe = 1'b1;
    cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    chk(!wb_cyc && cmd_ready, "R1", "zero-length command ignored",
        {wb_cyc, cmd_ready}, 2'b01);

    cmd_addr = 32'h2000; cmd_len = 8'd2; cmd_write = 1'b1; cmd_sel = 4'h3; cmd_pipe = 1'b0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(wb_cyc && wb_stb && wb_we && wb_adr == 32'h2000 && wb_sel == 4'h3, "R1",
        "first request after start", {wb_cyc, wb_stb, wb_we, wb_sel}, 7'b1110011);
    while (!cmd_ready) @(negedge clk);
    repeat (2) @(negedge clk);

    run_block(32'h1000, 1, 1'b0, 4'hF, 1'b0, 100, 0, 3);
    run_block(32'h1100, 4, 1'b0, 4'hF, 1'b0, 100, 0, 15);
    run_block(32'h1200, 4, 1'b1, 4'h5, 1'b0, 100, 60, 15);
    run_block(32'h1300, 4, 1'b0, 4'hF, 1'b1, 100, 0, 6);
    run_block(32'h1400, 8, 1'b1, 4'hC, 1'b1, 100, 0, 10);
    run_block(32'h1500, 12, 1'b1, 4'hF, 1'b1, 70, 50, 0);
    run_block(32'h1600, 1, 1'b0, 4'h1, 1'b1, 100, 0, 3);
    run_block(32'hFFFF_FFF8, 4, 1'b0, 4'hF, 1'b1, 100, 30, 0);

    for (int t = 0; t < 40; t++) begin
      run_block({$urandom} & 32'hFFFF_FFFC, 1 + int'($urandom % 24), 1'($urandom),
                4'($urandom | 1), 1'($urandom), 40 + int'($urandom % 61),
                int'($urandom % 60), 0);
    end

    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end
endmodule